// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output-compare channel with its own 16-bit timer. A compare pin is driven from two programmable match values. Match A marks the rising edge and match B marks the falling edge. The channel can flip the pin on every A match, emit a single pulse, or emit a pulse in every timer period. The timer counts up from zero and returns to zero after it reaches the period value. It advances only on cycles where the time-base enable from the selected clock source is high.

A source-select field picks one of several hardware event lines. In synchronous operation a selected event clears the timer. In triggered operation the timer is held at zero until a trigger arrives. The trigger can be a selected hardware event or a software request. A trigger status output shows whether the channel is armed and counting. If auto-clear is chosen, the status drops at each rollover, so the channel waits for the next trigger. Each match also raises an interrupt pulse one cycle long.

Top module: `ocu_top`

## Requirements
- R1: Reset, mode 000 and modes 100 to 111 all act as "off". Off forces `oc_out` low and `tmr_val` to 0, clears `trig_stat` and `match_irq`, and clears the single-pulse latch. The registered outputs take these values at the clock edge after the off mode is seen.
- R2: The timer is 16 bits wide and advances by one only on edges where `tick_en` is high and the timer is running. An advance from a value equal to `period` gives 0. Without an advance, the value holds.
- R3: In mode 001 (toggle), `oc_out` inverts at the edge that ends a cycle in which the timer advanced and `tmr_val` equalled `cmp_a`.
- R4: In mode 011 (repeating pulse), an A match drives `oc_out` high and a B match drives it low. When A and B match in the same cycle, B wins.
- R5: Mode 010 (single pulse) behaves like mode 011 until `oc_out` falls on a B match. After that, `oc_out` stays low until the channel is switched off.
- R6: `src_sel` 0 means no source. Values 1 to NSRC pick `evt_in[src_sel-1]`. Larger values also mean no source. With `trig_mode`=0 the timer runs freely, and a selected event clears it to 0 at the next edge, overriding any advance.
- R7: With `trig_mode`=1 the timer is held at 0 while `trig_stat` is low. `trig_stat` is set at the edge after `sw_trig` is high or the selected event is high. While `trig_stat` is high, the timer runs as in R2.
- R8: With `trig_mode`=1 and `auto_clr`=1, `trig_stat` clears at a rollover edge, unless a new trigger is present in that same cycle. With `auto_clr`=0 it stays set.
- R9: `match_irq` is high for exactly the cycle after each cycle that had an A or B match, with the channel on.
- R10: With `trig_mode`=0, `trig_stat` is 0 at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base count enable |
| mode | input | 3 | 000 off, 001 toggle, 010 single pulse, 011 repeating pulse |
| trig_mode | input | 1 | 0 synchronous, 1 triggered |
| auto_clr | input | 1 | Clear trigger status at rollover |
| src_sel | input | 5 | Event source select, 0 = none |
| evt_in | input | NSRC | Hardware sync/trigger event lines |
| sw_trig | input | 1 | Software trigger request |
| cmp_a | input | 16 | Rising-edge match value |
| cmp_b | input | 16 | Falling-edge match value |
| period | input | 16 | Last timer value before wrap |
| oc_out | output | 1 | Compare pin |
| match_irq | output | 1 | One-cycle match interrupt |
| trig_stat | output | 1 | Trigger armed status |
| tmr_val | output | 16 | Current timer value |

## Verification
The assertions assume that all control inputs are known after reset, and that `tick_en` is the only thing that moves the timer, apart from sync clears, trigger holds and mode changes. They also assume `period` does not fall below the running timer value. The stimulus holds `period`, `cmp_a` and `cmp_b` constant within each segment and keeps both compare values at or below the period. Events and software triggers are sparse random pulses on top of directed segments. Mode and trigger settings change only at segment boundaries, or through deliberate off pulses.

// File: rtl/ocu_pkg.sv
// Package: shared mode encoding and a helper for the compare channel.
// Assumes a 3-bit mode field; encodings outside the named ones mean off.
package ocu_pkg;

    typedef enum logic [2:0] {
        OCM_OFF    = 3'b000,
        OCM_TOGGLE = 3'b001,
        OCM_SINGLE = 3'b010,
        OCM_CONT   = 3'b011
    } ocm_e;

    // True when the mode field selects a working compare mode.
    function automatic logic mode_on(input logic [2:0] m);
        return (m == OCM_TOGGLE) || (m == OCM_SINGLE) || (m == OCM_CONT);
    endfunction

endpackage

// File: rtl/ocu_srcsel.sv
// Event source selector: picks one event line by a 1-based index.
// Assumes index 0 and indices above NSRC mean "no source".
module ocu_srcsel #(
    parameter int NSRC = 4,
    parameter int SELW = 5
) (
    input  logic [SELW-1:0] sel,
    input  logic [NSRC-1:0] evt,
    output logic            hit
);
    logic [NSRC-1:0] pick;

    // One decoder lane per event line.
    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        assign pick[i] = (sel == SELW'(i + 1)) && evt[i];
    end

    // Any selected lane produces the event.
    always_comb hit = |pick;
endmodule

// File: rtl/ocu_timebase.sv
// Timer and trigger logic: counts on tick, wraps at period, clears on
// a sync event, and holds at zero until armed in triggered operation.
// Assumes period is not lowered below the running count.
module ocu_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  logic         trig_mode,
    input  logic         auto_clr,
    input  logic         evt,
    input  logic         sw_trig,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         armed,
    output logic         adv
);
    logic run;
    logic wrap;
    logic fire;

    // Running condition, advance qualifier and rollover detect.
    always_comb begin
        run  = trig_mode ? armed : 1'b1;
        adv  = enable && tick && run;
        wrap = adv && (cnt == period);
        fire = evt || sw_trig;
    end

    // Timer register update.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (!trig_mode && evt) begin
            cnt <= '0;
        end else if (trig_mode && !armed) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= wrap ? '0 : cnt + W'(1);
        end
    end

    // Trigger status: set on trigger, optionally cleared at rollover.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !trig_mode) begin
            armed <= 1'b0;
        end else if (fire) begin
            armed <= 1'b1;
        end else if (wrap && auto_clr) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/ocu_match.sv
// Dual comparator: flags A and B equality on advancing cycles only.
// Assumes adv already folds in channel enable and run state.
module ocu_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         adv,
    output logic         hit_a,
    output logic         hit_b
);
    logic [1:0]   eq;
    logic [W-1:0] ref_v [2];

    assign ref_v[0] = cmp_a;
    assign ref_v[1] = cmp_b;

    // One comparator per compare value.
    for (genvar k = 0; k < 2; k++) begin : g_cmp
        assign eq[k] = adv && (cnt == ref_v[k]);
    end

    // Name the comparator results.
    always_comb begin
        hit_a = eq[0];
        hit_b = eq[1];
    end
endmodule

// File: rtl/ocu_wave.sv
// Waveform generator: turns match flags into pin behaviour per mode and
// raises a one-cycle interrupt per match cycle.
// Assumes hit flags are zero when the channel is off.
module ocu_wave
    import ocu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       hit_a,
    input  logic       hit_b,
    output logic       pin,
    output logic       irq
);
    logic enable;
    logic spent;
    logic pin_nx;
    logic spent_nx;

    // Next pin and single-pulse latch per mode.
    always_comb begin
        enable   = mode_on(mode);
        pin_nx   = pin;
        spent_nx = spent;
        case (mode)
            OCM_TOGGLE: if (hit_a) pin_nx = !pin;
            OCM_CONT: begin
                if (hit_b)      pin_nx = 1'b0;
                else if (hit_a) pin_nx = 1'b1;
            end
            OCM_SINGLE: begin
                if (spent) begin
                    pin_nx = 1'b0;
                end else if (hit_b) begin
                    pin_nx = 1'b0;
                    if (pin) spent_nx = 1'b1;
                end else if (hit_a) begin
                    pin_nx = 1'b1;
                end
            end
            default: pin_nx = 1'b0;
        endcase
    end

    // Pin, latch and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pin   <= 1'b0;
            spent <= 1'b0;
            irq   <= 1'b0;
        end else begin
            pin   <= pin_nx;
            spent <= spent_nx;
            irq   <= hit_a || hit_b;
        end
    end
endmodule

// File: rtl/ocu_top.sv
// Output compare channel top: source select, timer, comparators and
// waveform stage. Assumes all inputs synchronous to clk.
module ocu_top
    import ocu_pkg::*;
#(
    parameter int W    = 16,
    parameter int NSRC = 4,
    parameter int SELW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic [2:0]      mode,
    input  logic            trig_mode,
    input  logic            auto_clr,
    input  logic [SELW-1:0] src_sel,
    input  logic [NSRC-1:0] evt_in,
    input  logic            sw_trig,
    input  logic [W-1:0]    cmp_a,
    input  logic [W-1:0]    cmp_b,
    input  logic [W-1:0]    period,
    output logic            oc_out,
    output logic            match_irq,
    output logic            trig_stat,
    output logic [W-1:0]    tmr_val
);
    logic chan_on;
    logic evt_hit;
    logic adv;
    logic hit_a;
    logic hit_b;

    // Channel enable from the mode field.
    always_comb chan_on = mode_on(mode);

    ocu_srcsel #(.NSRC(NSRC), .SELW(SELW)) u_sel (
        .sel (src_sel),
        .evt (evt_in),
        .hit (evt_hit)
    );

    ocu_timebase #(.W(W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (chan_on),
        .tick      (tick_en),
        .trig_mode (trig_mode),
        .auto_clr  (auto_clr),
        .evt       (evt_hit),
        .sw_trig   (sw_trig),
        .period    (period),
        .cnt       (tmr_val),
        .armed     (trig_stat),
        .adv       (adv)
    );

    ocu_match #(.W(W)) u_cmp (
        .cnt   (tmr_val),
        .cmp_a (cmp_a),
        .cmp_b (cmp_b),
        .adv   (adv),
        .hit_a (hit_a),
        .hit_b (hit_b)
    );

    ocu_wave u_wav (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .hit_a (hit_a),
        .hit_b (hit_b),
        .pin   (oc_out),
        .irq   (match_irq)
    );
endmodule

// File: rtl/ocu_chk.sv
// Checker for ocu_top: port-level temporal properties, bound below.
// Assumes synchronous active-low reset on rst_n.
module ocu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic [2:0]   mode,
    input logic         trig_mode,
    input logic         oc_out,
    input logic         match_irq,
    input logic         trig_stat,
    input logic [W-1:0] tmr_val
);
    logic on_m;
    always_comb on_m = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd3);

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !on_m |=> (!oc_out && tmr_val == '0 && !trig_stat));

    p_hold_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (on_m && !tick_en && !trig_mode && tmr_val != '0) |=>
            (tmr_val == $past(tmr_val) || tmr_val == '0));

    p_pin_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (on_m && mode != 3'd2 && !tick_en) |=> $stable(oc_out));

    p_wait_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (on_m && trig_mode && !trig_stat) |=> tmr_val == '0);

    p_irq_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (on_m && !tick_en) |=> !match_irq);

    p_sync_unarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_mode |=> !trig_stat);
endmodule

bind ocu_top ocu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .mode      (mode),
    .trig_mode (trig_mode),
    .oc_out    (oc_out),
    .match_irq (match_irq),
    .trig_stat (trig_stat),
    .tmr_val   (tmr_val)
);

// File: tb/sim_ocu_top.sv
`timescale 1ns/1ps
module sim_ocu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        trig_mode = 1'b0;
    logic        auto_clr = 1'b0;
    logic [4:0]  src_sel = 5'd0;
    logic [3:0]  evt_in = 4'd0;
    logic        sw_trig = 1'b0;
    logic [15:0] cmp_a = 16'd0;
    logic [15:0] cmp_b = 16'd0;
    logic [15:0] period = 16'd0;
    logic        oc_out;
    logic        match_irq;
    logic        trig_stat;
    logic [15:0] tmr_val;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Expected state
    logic [15:0] m_cnt;
    logic        m_ts, m_oc, m_irq, m_done;

    always #2.5 clk = ~clk;

    ocu_top u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit on_f(input logic [2:0] m);
        return m == 3'd1 || m == 3'd2 || m == 3'd3;
    endfunction

    function automatic bit ev_f();
        if (src_sel >= 5'd1 && src_sel <= 5'd4) return evt_in[src_sel - 5'd1];
        return 1'b0;
    endfunction

    // Expected next state from the requirements.
    task automatic model_next();
        bit en, ev, run, adv, ha, hb, wrap;
        logic [15:0] c; logic ts, o, ir, d;
        en = on_f(mode); ev = ev_f();
        run = trig_mode ? m_ts : 1'b1;
        adv = en && tick_en && run;
        ha = adv && m_cnt == cmp_a; hb = adv && m_cnt == cmp_b;
        wrap = adv && m_cnt == period;
        c = m_cnt; ts = m_ts; o = m_oc; ir = 0; d = m_done;
        if (!en) begin c = 0; ts = 0; o = 0; d = 0; end
        else begin
            if (!trig_mode && ev) c = 0;
            else if (trig_mode && !m_ts) c = 0;
            else if (adv) c = wrap ? 16'd0 : m_cnt + 16'd1;
            if (!trig_mode) ts = 0;
            else if (ev || sw_trig) ts = 1;
            else if (wrap && auto_clr) ts = 0;
            ir = ha || hb;
            case (mode)
                3'd1: if (ha) o = !m_oc;
                3'd3: if (hb) o = 0; else if (ha) o = 1;
                default: begin
                    if (m_done) o = 0;
                    else if (hb) begin o = 0; if (m_oc) d = 1; end
                    else if (ha) o = 1;
                end
            endcase
        end
        m_cnt = c; m_ts = ts; m_oc = o; m_irq = ir; m_done = d;
    endtask

    task automatic step(input string req);
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk(req, "oc_out", int'(oc_out), int'(m_oc));
        chk(req, "match_irq", int'(match_irq), int'(m_irq));
        chk(req, "trig_stat", int'(trig_stat), int'(m_ts));
        chk(req, "tmr_val", int'(tmr_val), int'(m_cnt));
    endtask

    task automatic setup(input logic [2:0] md, input logic tm, input logic ac,
                         input logic [4:0] ss, input int a, input int b, input int p);
        mode = md; trig_mode = tm; auto_clr = ac; src_sel = ss;
        cmp_a = 16'(a); cmp_b = 16'(b); period = 16'(p);
        evt_in = 0; sw_trig = 0;
    endtask

    task automatic go_off();
        mode = 3'd0; tick_en = 0; evt_in = 0; sw_trig = 0;
        step("R1");
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int edges;
        logic prev;
        void'($urandom(32'd20240611));
        m_cnt = 0; m_ts = 0; m_oc = 0; m_irq = 0; m_done = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "reset oc_out", int'(oc_out), 0);
        chk("R1", "reset tmr_val", int'(tmr_val), 0);
        chk("R1", "reset trig_stat", int'(trig_stat), 0);

        // R5 single pulse: one rising edge only
        setup(3'd2, 0, 0, 0, 2, 5, 9); tick_en = 1; edges = 0; prev = 0;
        for (int i = 0; i < 40; i++) begin step("R5"); if (oc_out && !prev) edges++; prev = oc_out; end
        chk("R5", "single pulse edges", edges, 1);
        go_off();

        // R4 repeating pulse
        setup(3'd3, 0, 0, 0, 2, 5, 9); tick_en = 1; edges = 0; prev = 0;
        for (int i = 0; i < 40; i++) begin step("R4"); if (oc_out && !prev) edges++; prev = oc_out; end
        chk("R4", "repeat pulse edges", edges, 4);
        go_off();

        // R4 equal A and B: B wins, pin never high
        setup(3'd3, 0, 0, 0, 3, 3, 6); tick_en = 1; edges = 0;
        for (int i = 0; i < 20; i++) begin step("R4"); if (oc_out) edges++; end
        chk("R4", "equal compare high cycles", edges, 0);
        go_off();

        // R3 toggle
        setup(3'd1, 0, 0, 0, 4, 0, 9); tick_en = 1; edges = 0; prev = 0;
        for (int i = 0; i < 40; i++) begin step("R3"); if (oc_out != prev) edges++; prev = oc_out; end
        chk("R3", "toggle count", edges, 4);
        go_off();

        // R2 wrap at period and hold without tick
        setup(3'd3, 0, 0, 0, 1, 2, 3); tick_en = 1;
        for (int i = 0; i < 4; i++) step("R2");
        chk("R2", "wrap to zero", int'(tmr_val), 0);
        tick_en = 0;
        for (int i = 0; i < 3; i++) step("R2");
        chk("R2", "hold without tick", int'(tmr_val), 0);
        go_off();

        // R6 out-of-range source ignored, valid source clears
        setup(3'd3, 0, 0, 5'd7, 20, 30, 40); tick_en = 1; evt_in = 4'hF;
        for (int i = 0; i < 5; i++) step("R6");
        chk("R6", "ignored source", int'(tmr_val), 5);
        src_sel = 5'd3; evt_in = 4'b0100; step("R6");
        chk("R6", "sync clear", int'(tmr_val), 0);
        evt_in = 0; go_off();

        // R7 wait for trigger, R8 auto clear, R10 leave trigger mode
        setup(3'd3, 1, 1, 5'd2, 1, 2, 4); tick_en = 1;
        for (int i = 0; i < 6; i++) step("R7");
        chk("R7", "held before trigger", int'(tmr_val), 0);
        evt_in = 4'b0010; step("R7"); evt_in = 0;
        chk("R7", "hw trigger sets status", int'(trig_stat), 1);
        for (int i = 0; i < 5; i++) step("R8");
        chk("R8", "auto clear at rollover", int'(trig_stat), 0);
        sw_trig = 1; step("R7"); sw_trig = 0;
        chk("R7", "sw trigger sets status", int'(trig_stat), 1);
        auto_clr = 0;
        for (int i = 0; i < 12; i++) step("R8");
        chk("R8", "status kept without auto clear", int'(trig_stat), 1);
        trig_mode = 0; step("R10");
        chk("R10", "status cleared in sync mode", int'(trig_stat), 0);
        go_off();

        // Random segments
        for (int s = 0; s < 120; s++) begin
            int p, a, b, mv;
            string tag;
            p = 3 + int'($urandom % 13);
            a = int'($urandom % (p + 1)); b = int'($urandom % (p + 1));
            mv = int'($urandom % 8);
            setup(3'(mv), 1'($urandom % 2), 1'($urandom % 2), 5'($urandom % 7), a, b, p);
            case (mv)
                1: tag = "R3"; 2: tag = "R5"; 3: tag = "R4"; default: tag = "R1";
            endcase
            if (trig_mode) tag = {tag, "/R7/R8"}; else tag = {tag, "/R6"};
            for (int i = 0; i < 80; i++) begin
                tick_en = ($urandom % 10) < 7;
                evt_in = (($urandom % 12) == 0) ? 4'(1 << ($urandom % 4)) : 4'd0;
                sw_trig = ($urandom % 15) == 0;
                step({tag, "/R2/R9"});
            end
            if ((s % 4) == 0) go_off();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule